// File: doc/BRIEF.md
# Dual-Line Interrupt Flag Router

This block keeps one sticky status flag for each of a set of interrupt sources and turns those flags into two interrupt request lines. A flag is latched when its source input shows a rising edge. It then stays set, even after the source returns low, until software clears it by writing a one to its bit. Software can see the flag vector at any time through a small register port.

Each flag passes through two controls before it can reach an output. A per-flag enable decides whether the flag may raise an interrupt at all. A per-flag select bit then steers it to line 0 or line 1. Each line also has its own master enable. A line output is registered, so it follows a change of flags or configuration one clock later.

The register port is a simple valid/write/address interface whose data width equals the flag count. It has four registers. Address 0 is the flag vector, which reads the flags and clears them on a write of one. Address 1 is the enable mask. Address 2 is the line select. Address 3 holds the line enables.

Top module: `dual_line_irq_router`

## Requirements
- R1: A flag is set only in the cycle after a rising edge on its source input, where the previous sampled value was 0 and the current one is 1. A source held high does not set the flag again after it has been cleared. The first sample after reset counts as a rise if the source is already high.
- R2: A set flag stays set when its source input falls and while no clear reaches it.
- R3: A write to address 0 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: While the active-low reset is asserted, these all read zero: the flags, the enable mask, the line select, the line enables and both interrupt lines.
- R5: When a rising edge and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R6: A flag whose bit in the enable mask (address 1) is 0 still latches and reads back, but it drives neither line.
- R7: The line select register (address 2) steers each enabled flag. A select bit of 0 routes it to irqLine0 and a select bit of 1 routes it to irqLine1.
- R8: Bit 0 of the line-enable register (address 3) gates irqLine0 and bit 1 gates irqLine1. A disabled line stays low whatever the flags are.
- R9: Each line is a register. It equals, one clock later, the OR of the flags that are set, enabled and routed to it, ANDed with that line's enable.
- R10: regRdata always shows the register selected by regAddr, with no side effect from reading.
- R11: A register changes only when regValid and regWrite are both 1 in the same cycle. A cycle with either one low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_FLAGS | Source inputs, one per flag, rising-edge sensitive |
| regValid | input | 1 | Register access valid |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Register address (0 flags, 1 enable, 2 select, 3 line enables) |
| regWdata | input | NUM_FLAGS | Write data |
| regRdata | output | NUM_FLAGS | Read data of the addressed register |
| flagVec | output | NUM_FLAGS | Current flag vector |
| irqLine0 | output | 1 | Interrupt line 0 |
| irqLine1 | output | 1 | Interrupt line 1 |

## Verification
A new source edge and a software write-one clear can land on the same flag in one cycle. The bench provokes this twice. A directed step raises a source bit in exactly the cycle that a clear of that bit is written. A long random phase then mixes source toggles with frequent all-ones clears. A behavioural model, in which a set always overrides a clear, judges the flag vector and both lines on every clock.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [1:0] {
    REG_FLAGS   = 2'd0,
    REG_ENABLE  = 2'd1,
    REG_SELECT  = 2'd2,
    REG_LINE_EN = 2'd3
  } regSel_t;

  localparam int NUM_LINES = 2;

  typedef struct packed {
    logic clrFlags;
    logic wrEnable;
    logic wrSelect;
    logic wrLineEn;
  } regStrobes_t;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_FLAGS = 16,
  parameter int ADDR_W    = 2
) (
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_FLAGS-1:0] flagVec,
  input  logic [NUM_FLAGS-1:0] enMask,
  input  logic [NUM_FLAGS-1:0] selMask,
  input  logic [NUM_LINES-1:0] lineEn,
  output regStrobes_t          strobes,
  output logic [NUM_FLAGS-1:0] regRdata
);

  localparam int SEL_W = 2;

  logic        inRange;
  regSel_t     regSel;
  logic        doWrite;

  generate
    if (ADDR_W > SEL_W) begin : g_wideAddr
      assign inRange = (regAddr[ADDR_W-1:SEL_W] == '0);
    end else begin : g_narrowAddr
      assign inRange = 1'b1;
    end
  endgenerate

  assign regSel  = regSel_t'(regAddr[SEL_W-1:0]);
  assign doWrite = regValid && regWrite && inRange;

  always_comb begin
    strobes          = '0;
    strobes.clrFlags = doWrite && (regSel == REG_FLAGS);
    strobes.wrEnable = doWrite && (regSel == REG_ENABLE);
    strobes.wrSelect = doWrite && (regSel == REG_SELECT);
    strobes.wrLineEn = doWrite && (regSel == REG_LINE_EN);
  end

  always_comb begin
    regRdata = '0;
    if (inRange) begin
      unique case (regSel)
        REG_FLAGS:   regRdata = flagVec;
        REG_ENABLE:  regRdata = enMask;
        REG_SELECT:  regRdata = selMask;
        REG_LINE_EN: regRdata = NUM_FLAGS'(lineEn);
        default:     regRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_router_datapath.sv
module irq_router_datapath
  import irq_router_pkg::*;
#(
  parameter int NUM_FLAGS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] evtIn,
  input  regStrobes_t          strobes,
  input  logic [NUM_FLAGS-1:0] wdata,
  output logic [NUM_FLAGS-1:0] flagVec,
  output logic [NUM_FLAGS-1:0] enMask,
  output logic [NUM_FLAGS-1:0] selMask,
  output logic [NUM_LINES-1:0] lineEn,
  output logic                 irqLine0,
  output logic                 irqLine1
);

  logic [NUM_FLAGS-1:0] evtPrev;
  logic [NUM_FLAGS-1:0] riseVec;
  logic [NUM_FLAGS-1:0] clrVec;
  logic [NUM_FLAGS-1:0] flagNext;
  logic [NUM_LINES-1:0] lineHit;
  logic [NUM_LINES-1:0] lineQ;

  assign riseVec = evtIn & ~evtPrev;
  assign clrVec  = strobes.clrFlags ? wdata : '0;

  // per-flag cell: a set overrides a clear arriving in the same cycle
  generate
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      always_comb begin
        if (riseVec[f])     flagNext[f] = 1'b1;
        else if (clrVec[f]) flagNext[f] = 1'b0;
        else                flagNext[f] = flagVec[f];
      end
    end
  endgenerate

  // per-line OR of enabled, routed flags
  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic [NUM_FLAGS-1:0] routeMask;
      assign routeMask  = (l == 0) ? ~selMask : selMask;
      assign lineHit[l] = |(flagVec & enMask & routeMask);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtPrev <= '0;
      flagVec <= '0;
      enMask  <= '0;
      selMask <= '0;
      lineEn  <= '0;
      lineQ   <= '0;
    end else begin
      evtPrev <= evtIn;
      flagVec <= flagNext;
      if (strobes.wrEnable) enMask  <= wdata;
      if (strobes.wrSelect) selMask <= wdata;
      if (strobes.wrLineEn) lineEn  <= wdata[NUM_LINES-1:0];
      lineQ   <= lineHit & lineEn;
    end
  end

  assign irqLine0 = lineQ[0];
  assign irqLine1 = lineQ[1];

endmodule

// File: rtl/dual_line_irq_router.sv
module dual_line_irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_FLAGS = 16,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] evtIn,
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_FLAGS-1:0] regWdata,
  output logic [NUM_FLAGS-1:0] regRdata,
  output logic [NUM_FLAGS-1:0] flagVec,
  output logic                 irqLine0,
  output logic                 irqLine1
);

  regStrobes_t          strobes;
  logic [NUM_FLAGS-1:0] enMask;
  logic [NUM_FLAGS-1:0] selMask;
  logic [NUM_LINES-1:0] lineEn;

  irq_router_ctrl #(
    .NUM_FLAGS(NUM_FLAGS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .flagVec (flagVec),
    .enMask  (enMask),
    .selMask (selMask),
    .lineEn  (lineEn),
    .strobes (strobes),
    .regRdata(regRdata)
  );

  irq_router_datapath #(
    .NUM_FLAGS(NUM_FLAGS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .strobes (strobes),
    .wdata   (regWdata),
    .flagVec (flagVec),
    .enMask  (enMask),
    .selMask (selMask),
    .lineEn  (lineEn),
    .irqLine0(irqLine0),
    .irqLine1(irqLine1)
  );

endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
  parameter int NUM_FLAGS = 16,
  parameter int ADDR_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_FLAGS-1:0] evtIn,
  input logic                 regValid,
  input logic                 regWrite,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [NUM_FLAGS-1:0] regWdata,
  input logic [NUM_FLAGS-1:0] flagVec,
  input logic [NUM_FLAGS-1:0] enMask,
  input logic [NUM_FLAGS-1:0] selMask,
  input logic [1:0]           lineEn,
  input logic                 irqLine0,
  input logic                 irqLine1
);

  logic [NUM_FLAGS-1:0] evtSeen;
  logic [NUM_FLAGS-1:0] riseSeen;
  logic [NUM_FLAGS-1:0] clrSeen;
  logic [NUM_FLAGS-1:0] route0;
  logic [NUM_FLAGS-1:0] route1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtSeen <= '0;
    else       evtSeen <= evtIn;
  end

  assign riseSeen = evtIn & ~evtSeen;
  assign clrSeen  = (regValid && regWrite && regAddr == '0) ? regWdata : '0;
  assign route0   = flagVec & enMask & ~selMask;
  assign route1   = flagVec & enMask & selMask;

  assert_set_needs_edge_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagVec & ~$past(flagVec) & ~$past(riseSeen)) == '0));

  assert_clear_needs_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flagVec) & ~flagVec & ~$past(clrSeen)) == '0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(riseSeen) & ~flagVec) == '0));

  assert_line0_route_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqLine0 == ($past(lineEn[0]) && ($past(route0) != '0))));

  assert_line1_route_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqLine1 == ($past(lineEn[1]) && ($past(route1) != '0))));

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_clear_R4: assert (flagVec == '0 && !irqLine0 && !irqLine1);
    end
  end

endmodule

bind dual_line_irq_router irq_router_checker #(
  .NUM_FLAGS(NUM_FLAGS),
  .ADDR_W   (ADDR_W)
) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .evtIn   (evtIn),
  .regValid(regValid),
  .regWrite(regWrite),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .flagVec (flagVec),
  .enMask  (enMask),
  .selMask (selMask),
  .lineEn  (lineEn),
  .irqLine0(irqLine0),
  .irqLine1(irqLine1)
);

// File: tb/dual_line_irq_router_test.sv
`timescale 1ns/1ps
module dual_line_irq_router_test;

  localparam int N  = 16;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  evtIn = '0;
  logic          regValid = 1'b0;
  logic          regWrite = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [N-1:0]  regWdata = '0;
  logic [N-1:0]  regRdata;
  logic [N-1:0]  flagVec;
  logic          irqLine0;
  logic          irqLine1;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dual_line_irq_router #(.NUM_FLAGS(N), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regValid(regValid),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .flagVec(flagVec), .irqLine0(irqLine0),
    .irqLine1(irqLine1)
  );

  // behavioural reference model
  logic [N-1:0] mFlags = '0, mEn = '0, mSel = '0, mPrev = '0;
  logic [1:0]   mLine = '0;
  logic         mIrq0 = 1'b0, mIrq1 = 1'b0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFlags = '0; mEn = '0; mSel = '0; mPrev = '0; mLine = '0;
      mIrq0 = 1'b0; mIrq1 = 1'b0;
    end else begin
      bit hit0, hit1, wr;
      hit0 = 0; hit1 = 0;
      for (int i = 0; i < N; i++)
        if (mFlags[i] && mEn[i]) begin
          if (mSel[i]) hit1 = 1; else hit0 = 1;
        end
      mIrq0 = mLine[0] && hit0;
      mIrq1 = mLine[1] && hit1;
      wr = regValid && regWrite;
      for (int i = 0; i < N; i++) begin
        if (wr && regAddr == 0 && regWdata[i]) mFlags[i] = 1'b0;
        if (evtIn[i] && !mPrev[i]) mFlags[i] = 1'b1;
      end
      if (wr && regAddr == 1) mEn = regWdata;
      if (wr && regAddr == 2) mSel = regWdata;
      if (wr && regAddr == 3) mLine = regWdata[1:0];
      mPrev = evtIn;
    end
  end

  function automatic logic [N-1:0] modelRead(input logic [AW-1:0] a);
    case (a)
      0: return mFlags;
      1: return mEn;
      2: return mSel;
      default: return {{(N-2){1'b0}}, mLine};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R1 R2 R3 R5 flags", 32'(flagVec), 32'(mFlags));
      check("R9 irqLine0", 32'(irqLine0), 32'(mIrq0));
      check("R9 irqLine1", 32'(irqLine1), 32'(mIrq1));
      check("R10 regRdata", 32'(regRdata), 32'(modelRead(regAddr)));
    end
  end

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    regValid = 1; regWrite = 1; regAddr = a; regWdata = d;
    tick();
    regValid = 0; regWrite = 0; regWdata = '0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [N-1:0] exp);
    regAddr = a;
    #1;
    check(req, 32'(regRdata), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check("R4 flags in reset", 32'(flagVec), 0);
    check("R4 lines in reset", {irqLine1, irqLine0}, 0);
    rstN = 1;
    tick();
    rd("R4 enable after reset", 1, '0);
    rd("R4 select after reset", 2, '0);
    rd("R4 line enable after reset", 3, '0);

    wr(1, 16'hFFFF);
    wr(2, 16'h00F0);
    wr(3, 16'h0003);
    rd("R7 select readback", 2, 16'h00F0);
    rd("R8 line enable readback", 3, 16'h0003);

    // R9: flag first, line one clock later
    evtIn = 16'h0001; tick();
    check("R1 edge sets flag", 32'(flagVec), 32'h1);
    check("R9 line lags flag", 32'(irqLine0), 0);
    evtIn = '0; tick();
    check("R7 sel 0 goes to line0", 32'(irqLine0), 1);
    check("R7 sel 0 not line1", 32'(irqLine1), 0);
    check("R2 flag held after fall", 32'(flagVec), 32'h1);

    // R3: zero bits ignored, one bits clear
    wr(0, 16'h0000);
    check("R3 write zero no effect", 32'(flagVec), 32'h1);
    wr(0, 16'h0001);
    check("R3 write one clears", 32'(flagVec), 0);
    tick();
    check("R9 line drops after clear", 32'(irqLine0), 0);

    // R1: held level does not re-set after clear
    evtIn = 16'h0002; tick();
    check("R1 held source sets once", 32'(flagVec), 32'h2);
    wr(0, 16'h0002);
    tick();
    check("R1 held level no re-set", 32'(flagVec), 0);
    evtIn = '0; tick();

    // R5: edge and clear in the same cycle
    evtIn = 16'h0004;
    wr(0, 16'h0004);
    check("R5 set wins over clear", 32'(flagVec), 32'h4);
    evtIn = '0;
    wr(0, 16'hFFFF);
    tick();

    // R7: flag routed to line1
    evtIn = 16'h0010; tick(); evtIn = '0; tick();
    check("R7 sel 1 goes to line1", 32'(irqLine1), 1);
    check("R7 sel 1 not line0", 32'(irqLine0), 0);

    // R8: line0 master enable off
    wr(3, 16'h0002);
    evtIn = 16'h0001; tick(); evtIn = '0; tick();
    check("R8 disabled line0 stays low", 32'(irqLine0), 0);
    check("R8 line1 still on", 32'(irqLine1), 1);
    wr(3, 16'h0003);
    wr(0, 16'hFFFF);
    tick();

    // R6: masked flag latches but drives nothing
    wr(1, 16'hFFFE);
    evtIn = 16'h0001; tick(); evtIn = '0; tick();
    check("R6 masked flag latches", 32'(flagVec), 32'h1);
    check("R6 masked flag no line0", 32'(irqLine0), 0);

    // R11: incomplete accesses change nothing
    regValid = 1; regWrite = 0; regAddr = 1; regWdata = '0; tick();
    regValid = 0; regWrite = 1; regAddr = 0; regWdata = 16'hFFFF; tick();
    regWrite = 0; regWdata = '0;
    rd("R11 read-only access no write", 1, 16'hFFFE);
    check("R11 unvalidated write no clear", 32'(flagVec), 32'h1);

    // random phase, model compared every clock
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 9);
      evtIn = N'($urandom);
      if (r < 3) begin
        regValid = 1; regWrite = 1; regAddr = 0;
        regWdata = (r == 0) ? '1 : N'($urandom);
      end else if (r == 3) begin
        regValid = 1; regWrite = 1; regAddr = AW'($urandom_range(1, 3));
        regWdata = N'($urandom);
      end else begin
        regValid = ($urandom_range(0, 1) == 1); regWrite = 0;
        regAddr = AW'($urandom); regWdata = N'($urandom);
      end
      tick();
    end
    regValid = 0; regWrite = 0; evtIn = '0;
    tick();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule